// File: doc/BRIEF.md
# Chroma Decimator and Interpolator

This block resamples a YCbCr pixel stream, one pixel per clock, between full-resolution chroma and subsampled chroma. A direction input selects the decimating direction or the interpolating direction. In the decimating direction, full 4:4:4 pixels enter and a subsampled stream leaves. In the interpolating direction, a subsampled stream enters and 4:4:4 pixels are rebuilt. A 3-bit mode input selects one of these operations: plain pass-through, 4:2:2 without filtering, 4:2:2 with filtering, filtered 4:1:1, or halving or doubling of the sample rate of luma and both chroma components together.

Each accepted pixel produces a registered result on the next clock. A line-start flag marks the first pixel of every line. That pixel resets the pixel phase, and from it the filters rebuild their history, so samples from the previous line are never used. In subsampled formats the chroma travels on one multiplexed lane. Cb comes in the first slot of a group and Cr in the second. Luma passes through unchanged.

Top module: `chroma_resampler`

## Requirements
- R1: After reset, out_valid, out_y, out_c0 and out_c1 are all 0. On a clock with no accepted pixel and no pending repeat, out_valid is 0 on the next clock.
- R2: Mode 0, and the unused codes 5, 6 and 7, copy in_y, in_c0 and in_c1 to out_y, out_c0 and out_c1 one clock after in_valid, in both directions, with out_valid set.
- R3: The pixel carrying in_sol has phase 0. Each later accepted pixel adds one to the phase, modulo 4. Clocks without in_valid leave the phase unchanged.
- R4: Mode 1, dir_up=0: out_y is the pixel's luma and out_c1 is 0. At even phase out_c0 is that pixel's Cb. At odd phase out_c0 is the Cr of the preceding even-phase pixel.
- R5: Mode 2, dir_up=0: as R4, but the chroma is first filtered with the kernel (x[i-2] + 2x[i-1] + x[i] + 2) >> 2, where x[i] is the current pixel.
- R6: Mode 3, dir_up=0: chroma is filtered with (x[i-4] + 2x[i-3] + 2x[i-2] + 2x[i-1] + x[i] + 4) >> 3. Phase 0 carries filtered Cb and phase 1 carries the filtered Cr of the phase-0 pixel. Phases 2 and 3 carry 0.
- R7: In the filters, any sample position earlier than the line-start pixel takes that pixel's own value.
- R8: Mode 4, dir_up=0: only even-phase pixels produce out_valid, with their own Y, Cb and Cr. Odd-phase pixels produce no output.
- R9: Mode 1, dir_up=1: in_c0 carries Cb at even phase and Cr at odd phase, and in_c1 is ignored. out_c0 and out_c1 give the most recent Cb and Cr, counting the current pixel.
- R10: Modes 2 and 3, dir_up=1: Cb arrives at phase 0 and Cr at phase 1, where mode 2 counts phase modulo 2. On an arrival clock, the output is the half-up rounded mean of the new sample and the previous sample of the same component. The first sample of a line is paired with itself. On other clocks the output is the latest raw sample.
- R11: In the interpolating modes, out_c1 is 128 for pixels of a line before the line's first Cr arrives.
- R12: Mode 4, dir_up=1: an accepted pixel is output on the next clock. It is output again, unchanged, on the clock after that when no new pixel arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_up | input | 1 | 0 = decimate, 1 = interpolate |
| mode | input | 3 | Operating mode (0 pass, 1 4:2:2, 2 4:2:2 filtered, 3 4:1:1 filtered, 4 2:1 all) |
| in_valid | input | 1 | Input pixel accepted this clock |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_y | input | 8 | Input luma |
| in_c0 | input | 8 | Input Cb (full-rate) or multiplexed chroma (subsampled) |
| in_c1 | input | 8 | Input Cr (full-rate); ignored when subsampled |
| out_valid | output | 1 | Output pixel present |
| out_y | output | 8 | Output luma |
| out_c0 | output | 8 | Output Cb (full-rate) or multiplexed chroma (subsampled) |
| out_c1 | output | 8 | Output Cr (full-rate); 0 when subsampled |

## Verification
Decimation is driven with ramps whose chroma steps differ between Cb and Cr. A wrong tap weight, a missing rounding constant, or a Cb/Cr swap in the multiplexed lane therefore each give a different wrong value. Every filtered mode runs two lines back to back. The second line starts at a level far from the end of the first, so any history carried across the line-start pixel shows at once in its first outputs. The first line has odd length, so a phase that is not reset by in_sol lands Cr where Cb belongs. Idle gaps inside the 2:1 streams separate a phase that advances on valid pixels from one that advances on clocks. The interpolating runs pair a changing Cb and Cr sequence so that repetition, arrival-clock averaging and the neutral Cr value at line start can each be told apart.

// File: rtl/chroma_rs_pkg.sv
package chroma_rs_pkg;
  localparam int unsigned PIX_W      = 8;
  localparam int unsigned LONG_TAPS  = 5;
  localparam int unsigned HIST_DEPTH = LONG_TAPS - 1;
  localparam int unsigned PH_W       = 2;
  localparam int unsigned N_COMP     = 2;

  typedef logic [PIX_W-1:0] pix_t;
  typedef pix_t [HIST_DEPTH:0] win_t;

  localparam pix_t CHROMA_MID = pix_t'(1 << (PIX_W - 1));

  typedef enum logic [2:0] {
    RS_FULL     = 3'd0,
    RS_PAIR     = 3'd1,
    RS_PAIR_FLT = 3'd2,
    RS_QUAD_FLT = 3'd3,
    RS_HALF     = 3'd4
  } rs_mode_e;

  // rounded mean of two samples, half-up
  function automatic pix_t mean2(input pix_t a, input pix_t b);
    logic [PIX_W:0] acc;
    acc = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
    return acc[PIX_W:1];
  endfunction

  // three-tap smoothing, weights 1-2-1, divided by 4 with rounding
  function automatic pix_t tap3(input pix_t older, input pix_t mid, input pix_t newer);
    logic [PIX_W+1:0] acc;
    acc = {2'b00, older} + {1'b0, mid, 1'b0} + {2'b00, newer} + (PIX_W+2)'(2);
    return acc[PIX_W+1:2];
  endfunction

  // five-tap smoothing, weights 1-2-2-2-1, divided by 8 with rounding
  function automatic pix_t tap5(input pix_t a, input pix_t b, input pix_t c,
                                input pix_t d, input pix_t e);
    logic [PIX_W+2:0] acc;
    acc = {3'b000, a} + {2'b00, b, 1'b0} + {2'b00, c, 1'b0} + {2'b00, d, 1'b0}
        + {3'b000, e} + (PIX_W+3)'(4);
    return acc[PIX_W+2:3];
  endfunction
endpackage

// File: rtl/rs_phase.sv
module rs_phase
  import chroma_rs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            restart,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] next_q;

  assign phase = restart ? '0 : next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) next_q <= '0;
    else if (adv) next_q <= phase + 1'b1;
  end

  a_r3_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && restart) |=> (next_q == PH_W'(1)));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(next_q));
endmodule

// File: rtl/rs_history.sv
module rs_history
  import chroma_rs_pkg::*;
#(
  parameter int unsigned DEPTH = HIST_DEPTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  restart,
  input  pix_t                  sample,
  output logic [DEPTH:0][PIX_W-1:0] win
);
  logic [DEPTH-1:0][PIX_W-1:0] hist_q;

  assign win[0] = sample;
  for (genvar k = 1; k <= DEPTH; k++) begin : g_tap
    // positions before the line start repeat the line's first sample
    assign win[k] = restart ? sample : hist_q[k-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else if (adv) hist_q <= win[DEPTH-1:0];
  end

  a_r7_line_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && restart) |=> (hist_q[0] == hist_q[DEPTH-1]));
endmodule

// File: rtl/rs_decim.sv
module rs_decim
  import chroma_rs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  rs_mode_e        mode,
  input  logic [PH_W-1:0] phase,
  input  win_t            cb_win,
  input  win_t            cr_win,
  output pix_t            dec_c
);
  pix_t cr_hold_q;
  pix_t cb_pick, cr_pick;
  logic lead_slot, trail_slot;

  always_comb begin
    cb_pick    = cb_win[0];
    cr_pick    = cr_win[0];
    lead_slot  = 1'b0;
    trail_slot = 1'b0;
    unique case (mode)
      RS_PAIR: begin
        lead_slot  = !phase[0];
        trail_slot = phase[0];
      end
      RS_PAIR_FLT: begin
        cb_pick    = tap3(cb_win[2], cb_win[1], cb_win[0]);
        cr_pick    = tap3(cr_win[2], cr_win[1], cr_win[0]);
        lead_slot  = !phase[0];
        trail_slot = phase[0];
      end
      RS_QUAD_FLT: begin
        cb_pick    = tap5(cb_win[4], cb_win[3], cb_win[2], cb_win[1], cb_win[0]);
        cr_pick    = tap5(cr_win[4], cr_win[3], cr_win[2], cr_win[1], cr_win[0]);
        lead_slot  = (phase == PH_W'(0));
        trail_slot = (phase == PH_W'(1));
      end
      default: ;
    endcase
    dec_c = lead_slot ? cb_pick : (trail_slot ? cr_hold_q : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cr_hold_q <= '0;
    else if (adv && lead_slot) cr_hold_q <= cr_pick;
  end

  a_r4_cr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && trail_slot) |=> $stable(cr_hold_q));
endmodule

// File: rtl/rs_interp.sv
module rs_interp
  import chroma_rs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            restart,
  input  rs_mode_e        mode,
  input  logic [PH_W-1:0] phase,
  input  pix_t            c_in,
  output pix_t            icb,
  output pix_t            icr
);
  pix_t lcb_q, lcr_q;
  logic cr_seen_q;
  logic cb_arrive, cr_arrive, filt, cr_seen;
  pix_t prev_cb, prev_cr;

  always_comb begin
    cb_arrive = 1'b0;
    cr_arrive = 1'b0;
    filt      = (mode != RS_PAIR);
    unique case (mode)
      RS_PAIR, RS_PAIR_FLT: begin
        cb_arrive = !phase[0];
        cr_arrive = phase[0];
      end
      RS_QUAD_FLT: begin
        cb_arrive = (phase == PH_W'(0));
        cr_arrive = (phase == PH_W'(1));
      end
      default: ;
    endcase
  end

  assign cr_seen = !restart && cr_seen_q;
  assign prev_cb = restart ? c_in : lcb_q;
  assign prev_cr = cr_seen ? lcr_q : c_in;
  assign icb = cb_arrive ? (filt ? mean2(prev_cb, c_in) : c_in) : lcb_q;
  assign icr = cr_arrive ? (filt ? mean2(prev_cr, c_in) : c_in)
                         : (cr_seen ? lcr_q : CHROMA_MID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcb_q     <= '0;
      lcr_q     <= '0;
      cr_seen_q <= 1'b0;
    end else if (adv) begin
      if (cb_arrive) lcb_q <= c_in;
      if (cr_arrive) lcr_q <= c_in;
      cr_seen_q <= cr_seen | cr_arrive;
    end
  end

  a_r11_neutral_start: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && restart) |-> (icr == CHROMA_MID));
  a_r9_cb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cb_arrive) |=> (lcb_q == $past(c_in)));
endmodule

// File: rtl/chroma_resampler.sv
module chroma_resampler
  import chroma_rs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_up,
  input  logic [2:0] mode,
  input  logic       in_valid,
  input  logic       in_sol,
  input  logic [7:0] in_y,
  input  logic [7:0] in_c0,
  input  logic [7:0] in_c1,
  output logic       out_valid,
  output logic [7:0] out_y,
  output logic [7:0] out_c0,
  output logic [7:0] out_c1
);
  rs_mode_e        mode_e;
  logic [PH_W-1:0] pix_phase;
  logic [N_COMP-1:0][PIX_W-1:0] comp_in;
  win_t            win [N_COMP];
  pix_t            dec_c, icb, icr;
  logic            rep_q;
  logic            is_sub;

  assign mode_e  = rs_mode_e'(mode);
  assign comp_in = {in_c1, in_c0};
  assign is_sub  = (mode_e == RS_PAIR) || (mode_e == RS_PAIR_FLT) || (mode_e == RS_QUAD_FLT);

  rs_phase u_phase (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .restart(in_sol), .phase(pix_phase)
  );

  for (genvar g = 0; g < N_COMP; g++) begin : g_hist
    rs_history #(.DEPTH(HIST_DEPTH)) u_hist (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .restart(in_sol),
      .sample(comp_in[g]), .win(win[g])
    );
  end

  rs_decim u_decim (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .mode(mode_e), .phase(pix_phase),
    .cb_win(win[0]), .cr_win(win[1]), .dec_c(dec_c)
  );

  rs_interp u_interp (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .restart(in_sol), .mode(mode_e),
    .phase(pix_phase), .c_in(in_c0), .icb(icb), .icr(icr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c0    <= '0;
      out_c1    <= '0;
      rep_q     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      rep_q     <= 1'b0;
      if (in_valid) begin
        if (is_sub) begin
          out_valid <= 1'b1;
          out_y     <= in_y;
          out_c0    <= dir_up ? icb : dec_c;
          out_c1    <= dir_up ? icr : '0;
        end else if (mode_e == RS_HALF) begin
          if (dir_up || !pix_phase[0]) begin
            out_valid <= 1'b1;
            out_y     <= in_y;
            out_c0    <= in_c0;
            out_c1    <= in_c1;
          end
          rep_q <= dir_up;
        end else begin
          out_valid <= 1'b1;
          out_y     <= in_y;
          out_c0    <= in_c0;
          out_c1    <= in_c1;
        end
      end else if (rep_q) begin
        out_valid <= 1'b1;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !rep_q) |=> !out_valid);
  a_r2_pass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_sub && mode_e != RS_HALF) |=>
      (out_valid && out_y == $past(in_y) && out_c1 == $past(in_c1)));
  a_r4_luma_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_sub) |=> (out_valid && out_y == $past(in_y)));
  a_r4_second_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_sub && !dir_up) |=> (out_c1 == '0));
  a_r8_odd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dir_up && mode_e == RS_HALF && pix_phase[0]) |=> !out_valid);
  a_r12_repeat_same: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_q && !in_valid) |=> (out_valid && $stable(out_y) && $stable(out_c0)));
endmodule

// File: tb/chroma_resampler_bench.sv
module chroma_resampler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_up = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       in_valid = 1'b0;
  logic       in_sol = 1'b0;
  logic [7:0] in_y = '0, in_c0 = '0, in_c1 = '0;
  logic       out_valid;
  logic [7:0] out_y, out_c0, out_c1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int yv [16];
  int cbv[16];
  int crv[16];

  always #5 clk = ~clk;

  chroma_resampler u_chroma_resampler (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .mode(mode),
    .in_valid(in_valid), .in_sol(in_sol), .in_y(in_y), .in_c0(in_c0), .in_c1(in_c1),
    .out_valid(out_valid), .out_y(out_y), .out_c0(out_c0), .out_c1(out_c1)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int y, input int c0, input int c1, input bit sol);
    @(negedge clk);
    in_valid = 1'b1; in_sol = sol;
    in_y = 8'(y); in_c0 = 8'(c0); in_c1 = 8'(c1);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sol = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic fill(input int seed, input int base);
    for (int i = 0; i < 16; i++) begin
      yv[i]  = (base + i * 17 + seed) & 255;
      cbv[i] = (base + i * 23 + seed * 5) & 255;
      crv[i] = (255 - base - i * 31 - seed) & 255;
    end
  endtask

  function automatic int cb_at(input int i); return cbv[(i < 0) ? 0 : i]; endfunction
  function automatic int cr_at(input int i); return crv[(i < 0) ? 0 : i]; endfunction

  function automatic int smooth3(input bit use_cr, input int i);
    int s;
    if (use_cr) s = cr_at(i-2) + 2*cr_at(i-1) + cr_at(i);
    else        s = cb_at(i-2) + 2*cb_at(i-1) + cb_at(i);
    return (s + 2) / 4;
  endfunction

  function automatic int smooth5(input bit use_cr, input int i);
    int s;
    if (use_cr) s = cr_at(i-4) + 2*(cr_at(i-3) + cr_at(i-2) + cr_at(i-1)) + cr_at(i);
    else        s = cb_at(i-4) + 2*(cb_at(i-3) + cb_at(i-2) + cb_at(i-1)) + cb_at(i);
    return (s + 4) / 8;
  endfunction

  task automatic t_reset();
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "out_y after reset", out_y, 0);
    chk("R1", "out_c0 after reset", out_c0, 0);
    chk("R1", "out_c1 after reset", out_c1, 0);
  endtask

  task automatic t_bypass(input int md, input bit up);
    mode = 3'(md); dir_up = up;
    fill(md, 40);
    for (int i = 0; i < 4; i++) begin
      push(yv[i], cbv[i], crv[i], i == 0);
      chk("R2", "valid", out_valid, 1);
      chk("R2", "y", out_y, yv[i]);
      chk("R2", "c0", out_c0, cbv[i]);
      chk("R2", "c1", out_c1, crv[i]);
    end
    idle();
    chk("R1", "valid after idle", out_valid, 0);
  endtask

  // one decimated line; expected values from R4/R5/R6 with R7 edge replication
  task automatic dec_line(input int md, input int n, input int seed, input int base, input string req);
    fill(seed, base);
    for (int i = 0; i < n; i++) begin
      int e;
      push(yv[i], cbv[i], crv[i], i == 0);
      if (md == 1)      e = (i % 2 == 0) ? cbv[i] : crv[i-1];
      else if (md == 2) e = (i % 2 == 0) ? smooth3(0, i) : smooth3(1, i-1);
      else              e = (i % 4 == 0) ? smooth5(0, i) : (i % 4 == 1) ? smooth5(1, i-1) : 0;
      chk(req, "valid", out_valid, 1);
      chk(req, "y", out_y, yv[i]);
      chk(req, $sformatf("chroma lane pixel %0d", i), out_c0, e);
      chk(req, "second lane", out_c1, 0);
    end
  endtask

  task automatic t_decim(input int md, input string req);
    mode = 3'(md); dir_up = 1'b0;
    dec_line(md, 7, md, 10, req);
    dec_line(md, 9, md + 3, 200, "R7_R3");   // new line: no carry-over, phase restarts
  endtask

  task automatic t_dec_half();
    mode = 3'd4; dir_up = 1'b0;
    fill(9, 70);
    for (int i = 0; i < 6; i++) begin
      push(yv[i], cbv[i], crv[i], i == 0);
      chk("R8", $sformatf("valid pixel %0d", i), out_valid, (i % 2 == 0) ? 1 : 0);
      if (i % 2 == 0) begin
        chk("R8", "y", out_y, yv[i]);
        chk("R8", "cb", out_c0, cbv[i]);
        chk("R8", "cr", out_c1, crv[i]);
      end
      if (i == 2) begin
        idle();
        chk("R3", "idle gives no output", out_valid, 0);
      end
    end
  endtask

  // interpolation: line built of y, multiplexed chroma from cbv/crv per slot
  task automatic int_line(input int md, input int n, input int seed, input int base, input string req);
    int lcb, lcr, slot, c, ecb, ecr;
    bit have_cr, filt;
    fill(seed, base);
    filt = (md != 1);
    have_cr = 1'b0; lcb = 0; lcr = 0;
    for (int i = 0; i < n; i++) begin
      slot = (md == 3) ? (i % 4) : (i % 2);
      c = (slot == 1) ? crv[i] : cbv[i];
      push(yv[i], c, 77, i == 0);
      if (slot == 0) begin
        ecb = filt ? (((i == 0) ? c : lcb) + c + 1) / 2 : c;
        lcb = c;
      end else ecb = lcb;
      if (slot == 1) begin
        ecr = filt ? ((have_cr ? lcr : c) + c + 1) / 2 : c;
        lcr = c; have_cr = 1'b1;
      end else ecr = have_cr ? lcr : 128;
      chk(req, "valid", out_valid, 1);
      chk(req, "y", out_y, yv[i]);
      chk(req, $sformatf("cb pixel %0d", i), out_c0, ecb);
      chk((!have_cr) ? "R11" : req, $sformatf("cr pixel %0d", i), out_c1, ecr);
    end
  endtask

  task automatic t_interp(input int md, input string req);
    mode = 3'(md); dir_up = 1'b1;
    int_line(md, 7, md + 11, 30, req);
    int_line(md, 8, md + 17, 180, req);
  endtask

  task automatic t_int_half();
    mode = 3'd4; dir_up = 1'b1;
    fill(21, 90);
    for (int i = 0; i < 3; i++) begin
      push(yv[i], cbv[i], crv[i], i == 0);
      chk("R12", "first copy valid", out_valid, 1);
      chk("R12", "first copy y", out_y, yv[i]);
      idle();
      chk("R12", "repeat valid", out_valid, 1);
      chk("R12", "repeat y", out_y, yv[i]);
      chk("R12", "repeat cb", out_c0, cbv[i]);
      chk("R12", "repeat cr", out_c1, crv[i]);
    end
    idle();
    chk("R1", "quiet after repeat", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_bypass(0, 1'b0);
    t_bypass(6, 1'b1);
    t_decim(1, "R4");
    t_decim(2, "R5");
    t_decim(3, "R6");
    t_dec_half();
    t_interp(1, "R9");
    t_interp(2, "R10");
    t_interp(3, "R10");
    t_int_half();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule